// File: doc/BRIEF.md
# Expansion Card Address Decoder

This block sits behind a byte-addressed bus window on an expansion card that carries two IDE channels. Each bus access is decoded into a chip select for one channel's command-block registers or its alternate-status/device-control register. The decoder also supplies the 3-bit register index that goes to the drive. One configuration byte is held on the card. It gates every drive-side chip select and picks which channel gets the DMA request/acknowledge pair. A 4-bit card identity, taken from strap inputs, can be read back one bit at a time.

Decoding is purely combinational on the current bus address and strobes. A configuration write takes effect on the next clock edge. Taskfile data moves between the host and the drive outside this block, so a taskfile read returns zero on the block's own read-data port. The identity reads let software tell the dual-channel card (identity 3) from the single-channel card (identity 15). Identities 0 and 1 mark older variants that software rejects.

Top module: `cardDecoder`

## Requirements
- R1: After reset the configuration byte is 0, so a read at address 0x0000 returns 0, `dmaChan` is 0 and no chip select is active.
- R2: A write at address 0x0000 stores `busWrData` into the configuration byte on that clock edge. Later reads at 0x0000 return it, and `dmaChan` follows its bit 0 (1 = channel 1, 0 = channel 0).
- R3: While configuration bit 5 is set, an access at 0x2000 + 64·n (n = 0..7) asserts only `tfCs[0]`, with `tfIdx` = n.
- R4: While configuration bit 5 is set, an access at 0x3000 + 64·n (n = 0..7) asserts only `tfCs[1]`, with `tfIdx` = n.
- R5: While configuration bit 5 is set, an access at 0x2380 asserts only `altCs[0]` and an access at 0x3380 asserts only `altCs[1]`.
- R6: While configuration bit 5 is clear, including after a write of 0, no `tfCs` or `altCs` bit is asserted at any address.
- R7: A read at 0x2280 + 4·k (k = 0..3) returns `cardId[k]` in bit 0 and zero in bits 7..1, whatever the configuration byte holds.
- R8: An access at any address not named in R2 to R7 (including misaligned neighbours of decoded addresses) asserts no chip select and reads as zero.
- R9: With neither `busRd` nor `busWr` high, no chip select is asserted, `busRdData` is zero and `tfIdx` is zero.
- R10: A write to any address other than 0x0000 leaves the configuration byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 14 | Byte address within the card window |
| busRd | input | 1 | Read strobe for the current cycle |
| busWr | input | 1 | Write strobe for the current cycle |
| busWrData | input | 8 | Write data |
| cardId | input | 4 | Strapped card identity |
| busRdData | output | 8 | Read data for configuration and identity locations, zero elsewhere |
| tfCs | output | 2 | Taskfile chip select, one bit per channel |
| altCs | output | 2 | Alternate-status/control chip select, one bit per channel |
| tfIdx | output | 3 | Taskfile register index, zero when no taskfile is selected |
| dmaChan | output | 1 | Channel that receives the DMA request/acknowledge |

## Verification
The assertions assume the bus never raises `busRd` and `busWr` in the same cycle, and that address, strobes and write data are held stable across each clock edge. The stimulus drives every access just after a rising edge, holds it for one full cycle and asserts at most one strobe at a time. Each cycle, a behavioural model in the bench compares all outputs against the address map and the modelled configuration byte.

// File: rtl/cardDecPkg.sv
package cardDecPkg;
  parameter int NUM_CH   = 2;
  parameter int TF_REGS  = 8;
  parameter int TF_IDX_W = $clog2(TF_REGS);
  parameter int ID_BITS  = 4;
  parameter int ID_SEL_W = $clog2(ID_BITS);
  parameter int EXT_BIT  = 5;
  parameter int DMA_BIT  = 0;

  typedef struct packed {
    logic                cfgWr;
    logic                cfgRd;
    logic                idRd;
    logic [ID_SEL_W-1:0] idSel;
    logic [NUM_CH-1:0]   tfHit;
    logic [NUM_CH-1:0]   altHit;
    logic [TF_IDX_W-1:0] regIdx;
  } decStrobeT;
endpackage

// File: rtl/cardDecodeCtl.sv
module cardDecodeCtl
  import cardDecPkg::*;
#(
  parameter int ADDR_W        = 14,
  parameter int STRIDE_LOG2   = 6,
  parameter int CH_BASE       = 'h2000,
  parameter int CH_SPAN       = 'h1000,
  parameter int ALT_OFS       = 'h380,
  parameter int ID_BASE       = 'h2280,
  parameter int ID_STEP_LOG2  = 2,
  parameter int CFG_ADDR      = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output decStrobeT         strb
);
  localparam logic [ADDR_W-1:0] TF_SPAN  = ADDR_W'(TF_REGS << STRIDE_LOG2);
  localparam logic [ADDR_W-1:0] ID_SPAN  = ADDR_W'(ID_BITS << ID_STEP_LOG2);
  localparam logic [ADDR_W-1:0] ID_ADDR  = ADDR_W'(ID_BASE);
  localparam logic [ADDR_W-1:0] CFG_A    = ADDR_W'(CFG_ADDR);

  logic                access;
  logic [NUM_CH-1:0]   tfHitCh;
  logic [NUM_CH-1:0]   altHitCh;
  logic [TF_IDX_W-1:0] idxCh [NUM_CH];
  logic [ADDR_W-1:0]   idOffs;
  logic                idHit;

  assign access = busRd | busWr;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(CH_BASE + ch * CH_SPAN);
    localparam logic [ADDR_W-1:0] ALT_ADR = ADDR_W'(CH_BASE + ch * CH_SPAN + ALT_OFS);
    logic [ADDR_W-1:0] offs;
    assign offs         = busAddr - BASE;
    assign tfHitCh[ch]  = access && (offs < TF_SPAN) &&
                          (offs[STRIDE_LOG2-1:0] == '0);
    assign idxCh[ch]    = offs[STRIDE_LOG2 +: TF_IDX_W];
    assign altHitCh[ch] = access && (busAddr == ALT_ADR);
  end

  assign idOffs = busAddr - ID_ADDR;
  assign idHit  = (idOffs < ID_SPAN) && (idOffs[ID_STEP_LOG2-1:0] == '0);

  always_comb begin
    strb        = '0;
    strb.tfHit  = tfHitCh;
    strb.altHit = altHitCh;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (tfHitCh[ch]) strb.regIdx = idxCh[ch];
    end
    strb.cfgWr = busWr && (busAddr == CFG_A);
    strb.cfgRd = busRd && (busAddr == CFG_A);
    strb.idRd  = busRd && idHit;
    strb.idSel = idOffs[ID_STEP_LOG2 +: ID_SEL_W];
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd || busWr) |-> (strb.tfHit == '0 && strb.altHit == '0 &&
                           !strb.cfgWr && !strb.cfgRd && !strb.idRd));

  // R8
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.tfHit, strb.altHit, strb.cfgRd | strb.cfgWr, strb.idRd}));
endmodule

// File: rtl/cardDecodeDp.sv
module cardDecodeDp
  import cardDecPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  decStrobeT           strb,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [ID_BITS-1:0]  cardId,
  output logic [DATA_W-1:0]   busRdData,
  output logic [NUM_CH-1:0]   tfCs,
  output logic [NUM_CH-1:0]   altCs,
  output logic [TF_IDX_W-1:0] tfIdx,
  output logic                dmaChan
);
  logic [DATA_W-1:0] cfgReg;
  logic              extEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cfgReg <= '0;
    else if (strb.cfgWr) cfgReg <= busWrData;
  end

  assign extEn   = cfgReg[EXT_BIT];
  assign dmaChan = cfgReg[DMA_BIT];
  assign tfCs    = strb.tfHit  & {NUM_CH{extEn}};
  assign altCs   = strb.altHit & {NUM_CH{extEn}};
  assign tfIdx   = (|tfCs) ? strb.regIdx : '0;

  always_comb begin
    busRdData = '0;
    if (strb.cfgRd)     busRdData = cfgReg;
    else if (strb.idRd) busRdData = {{(DATA_W-1){1'b0}}, cardId[strb.idSel]};
  end

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgWr |=> (dmaChan == $past(busWrData[DMA_BIT])));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgWr |=> $stable(dmaChan));

  // R6
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !extEn |-> (tfCs == '0 && altCs == '0));

  // R7
  id_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.idRd |-> (busRdData[DATA_W-1:1] == '0));

  // R9
  no_drive_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd || busWr) |-> (busRdData == '0 && tfIdx == '0));
endmodule

// File: rtl/cardDecoder.sv
module cardDecoder
  import cardDecPkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [ID_BITS-1:0]  cardId,
  output logic [DATA_W-1:0]   busRdData,
  output logic [NUM_CH-1:0]   tfCs,
  output logic [NUM_CH-1:0]   altCs,
  output logic [TF_IDX_W-1:0] tfIdx,
  output logic                dmaChan
);
  decStrobeT strb;

  cardDecodeCtl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .strb(strb)
  );

  cardDecodeDp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busRd(busRd), .busWr(busWr),
    .busWrData(busWrData), .cardId(cardId), .busRdData(busRdData),
    .tfCs(tfCs), .altCs(altCs), .tfIdx(tfIdx), .dmaChan(dmaChan)
  );
endmodule

// File: tb/cardDecoder_bench.sv
module cardDecoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [3:0]  cardId = 4'd3;
  logic [7:0]  busRdData;
  logic [1:0]  tfCs, altCs;
  logic [2:0]  tfIdx;
  logic        dmaChan;

  int    checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";
  logic [7:0] cfgModel;
  bit    done = 0;

  always #10 clk = ~clk;

  cardDecoder u_cardDecoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWrData(busWrData), .cardId(cardId), .busRdData(busRdData),
    .tfCs(tfCs), .altCs(altCs), .tfIdx(tfIdx), .dmaChan(dmaChan)
  );

  // behavioural model of the configuration byte
  always @(posedge clk or negedge rstN) begin
    if (!rstN) cfgModel <= 8'h00;
    else if (busWr && busAddr == 14'h0000) cfgModel <= busWrData;
  end

  // expected outputs from the address map
  always @(negedge clk) begin
    logic [1:0] eTf, eAlt;
    logic [2:0] eIdx;
    logic [7:0] eRd;
    bit act;
    act = busRd || busWr;
    eTf = '0; eAlt = '0; eIdx = '0; eRd = '0;
    if (act && cfgModel[5]) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int n = 0; n < 8; n++)
          if (int'(busAddr) == 'h2000 + ch * 'h1000 + n * 64) begin
            eTf[ch] = 1'b1; eIdx = 3'(n);
          end
        if (int'(busAddr) == 'h2380 + ch * 'h1000) eAlt[ch] = 1'b1;
      end
    end
    if (busRd && busAddr == 14'h0000) eRd = cfgModel;
    for (int k = 0; k < 4; k++)
      if (busRd && int'(busAddr) == 'h2280 + 4 * k) eRd = {7'b0, cardId[k]};
    checks++;
    if (tfCs !== eTf || altCs !== eAlt || tfIdx !== eIdx ||
        busRdData !== eRd || dmaChan !== cfgModel[0]) begin
      fails++;
      $display("FAIL %s addr=%h got tfCs=%b altCs=%b idx=%0d rd=%h dma=%b exp tfCs=%b altCs=%b idx=%0d rd=%h dma=%b",
               curReq, busAddr, tfCs, altCs, tfIdx, busRdData, dmaChan,
               eTf, eAlt, eIdx, eRd, cfgModel[0]);
    end
  end

  task automatic acc(input logic [13:0] a, input bit rd, input bit wr,
                     input logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busRd = rd; busWr = wr; busWrData = d;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    busRd = 0; busWr = 0;
  endtask

  task automatic sweepDrive();
    for (int ch = 0; ch < 2; ch++) begin
      for (int n = 0; n < 8; n++) begin
        acc(14'('h2000 + ch * 'h1000 + n * 64), 1, 0, 8'h00);
        acc(14'('h2000 + ch * 'h1000 + n * 64), 0, 1, 8'h5A);
      end
      acc(14'('h2380 + ch * 'h1000), 1, 0, 8'h00);
      acc(14'('h2380 + ch * 'h1000), 0, 1, 8'h33);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    curReq = "R1";
    acc(14'h0000, 1, 0, 0);
    @(negedge clk);
    checks++;
    if (busRdData !== 8'h00 || dmaChan !== 1'b0 || tfCs !== 2'b00) begin
      fails++;
      $display("FAIL R1 rd=%h dma=%b tfCs=%b exp 00 0 00", busRdData, dmaChan, tfCs);
    end
    // R6: gated while bit 5 clear
    curReq = "R6"; sweepDrive();
    // R2: enable extended region, DMA to channel 0
    curReq = "R2"; acc(14'h0000, 0, 1, 8'h20); acc(14'h0000, 1, 0, 0);
    // R3 R4 R5: decode both channels
    curReq = "R3_R4_R5"; sweepDrive();
    // R2: route DMA to channel 1
    curReq = "R2"; acc(14'h0000, 0, 1, 8'h21); acc(14'h0000, 1, 0, 0);
    // R7: identity readback under several straps
    curReq = "R7";
    foreach (cardId[i]) ;
    cardId = 4'd3;   for (int k = 0; k < 4; k++) acc(14'('h2280 + 4 * k), 1, 0, 0);
    cardId = 4'd15;  for (int k = 0; k < 4; k++) acc(14'('h2280 + 4 * k), 1, 0, 0);
    cardId = 4'hA;   for (int k = 0; k < 4; k++) acc(14'('h2280 + 4 * k), 1, 0, 0);
    // R8 R10: undecoded addresses, reads and writes
    curReq = "R8_R10";
    acc(14'h2001, 1, 0, 0); acc(14'h2044, 1, 0, 0); acc(14'h2200, 1, 0, 0);
    acc(14'h2290, 1, 0, 0); acc(14'h2281, 1, 0, 0); acc(14'h0001, 0, 1, 8'hFF);
    acc(14'h3FFF, 0, 1, 8'h00); acc(14'h1000, 1, 0, 0); acc(14'h2400, 0, 1, 8'h00);
    acc(14'h2381, 1, 0, 0); acc(14'h33C0, 0, 1, 8'h00); acc(14'h0000, 1, 0, 0);
    // R9: idle bus parked on decoded addresses
    curReq = "R9";
    acc(14'h2040, 0, 0, 0); idle(); acc(14'h0000, 0, 0, 0); acc(14'h2284, 0, 0, 0);
    // R6: writing 0 closes the extended region; identity still readable (R7)
    curReq = "R6"; acc(14'h0000, 0, 1, 8'h00); sweepDrive();
    curReq = "R7"; acc(14'h2288, 1, 0, 0);
    // R1: reset mid-run restores zero
    curReq = "R2"; acc(14'h0000, 0, 1, 8'hFF);
    curReq = "R1"; idle();
    #2 rstN = 1'b0; #20 rstN = 1'b1;
    acc(14'h0000, 1, 0, 0); acc(14'h2000, 1, 0, 0);
    idle(); idle();
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk); cycles++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired, got no completion exp completion");
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule